// File: doc/BRIEF.md
# Byte-Fed CRC-16 Group Checker

This block checks the integrity of a data group of any length with a 16-bit cyclic redundancy check. The host sends the group one byte at a time on a write strobe. The write may come from a parallel register write or from a byte that a serial receiver has assembled. After the data, the host sends the 16-bit check word, high byte first. If the group arrived intact, the division register is then all zeros, and the block reports a pass.

A control level, `hold_clr`, keeps the division register cleared for as long as it is high. The host raises it before a group and lowers it again. After a group that passes, the register is already zero, so the next group can follow without a clear.

The pass result appears in two places. A registered output pin follows the register continuously. A status bit captures the zero test on each status read strobe. A build parameter selects how each byte is folded into the register: in one clock, or bit by bit, MSB first, over eight clocks.

Top module: `crc_group_checker`

## Requirements
- R1: The generator is x^16 + x^12 + x^5 + 1 (0x1021), the register starts at zero, and each byte is taken MSB first. Any message followed by its own check word (high byte first) leaves the register at zero. For the ASCII bytes "123456789" the check word is 0x31C3.
- R2: There is no limit on group length. A group of several hundred bytes followed by its check word passes.
- R3: `pass_o` is high exactly when every register bit is zero and no byte is being absorbed. It is registered: in the single-clock variant it changes on the clock edge after the edge that absorbs the byte.
- R4: While `hold_clr` is high, the register is held at zero and `pass_o` is high from the second edge on.
- R5: A byte written while `hold_clr` is high is discarded. After `hold_clr` falls, the register is still zero.
- R6: After a group passes, a second group with its check word passes without any clear in between.
- R7: On a clock where `stat_rd` is high, `stat_pass` takes the zero test of the register as it stands at that edge. It does not change on any other clock.
- R8: In the bitwise variant (`MODE`=1), `busy` is high for 8 clocks after a byte is accepted. A byte written while `busy` is high is dropped. The final result equals that of the single-clock variant.
- R9: The synchronous reset `rst` clears the register, sets `pass_o` high and sets `stat_pass` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_clr | input | 1 | Level: holds the division register cleared |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to absorb |
| stat_rd | input | 1 | Status read strobe; captures the zero test |
| busy | output | 1 | Bitwise variant is absorbing a byte |
| pass_o | output | 1 | Registered zero-residue pass pin |
| stat_pass | output | 1 | Pass bit captured at the last status read |

## Verification
The bench builds two instances with the default polynomial and byte width. One uses `MODE`=0 (single-clock update) and the other uses `MODE`=1 (bitwise update). Both take the same writes, spaced wide enough for the bitwise engine. This lets the two variants be compared on the same table of groups, corrupted check words, a long group and the known-answer string. The default parallel instance also exposes the exact one-clock latency of the pass pin. Only the bitwise instance can show writes being dropped while it is busy.

// File: rtl/crc_group_pkg.sv
package crc_group_pkg;
  localparam int CRC_W = 16;
  typedef logic [CRC_W-1:0] crc_t;

  typedef enum logic {
    UPD_PARALLEL = 1'b0,
    UPD_BITWISE  = 1'b1
  } upd_mode_e;

  // One shift step of an MSB-first division register.
  function automatic crc_t crc_bit_step(input crc_t cur, input logic din, input crc_t poly);
    logic fb;
    fb = cur[CRC_W-1] ^ din;
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/crc_byte_engine.sv
module crc_byte_engine
  import crc_group_pkg::*;
#(
  parameter crc_t POLY   = 16'h1021,
  parameter int   DATA_W = 8,
  parameter bit   MODE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output crc_t              crc_q,
  output logic              busy
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  generate
    if (MODE == UPD_PARALLEL) begin : g_par
      crc_t nxt;
      always_comb begin
        nxt = crc_q;
        for (int i = DATA_W - 1; i >= 0; i--) begin
          nxt = crc_bit_step(nxt, wr_data[i], POLY);
        end
      end
      always_ff @(posedge clk) begin
        if (rst || hold_clr) crc_q <= '0;
        else if (wr_en)      crc_q <= nxt;
      end
      assign busy = 1'b0;
    end else begin : g_bit
      logic [CNT_W-1:0]  cnt;
      logic [DATA_W-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst || hold_clr) begin
          crc_q <= '0;
          cnt   <= '0;
          sh    <= '0;
        end else if (cnt != '0) begin
          crc_q <= crc_bit_step(crc_q, sh[DATA_W-1], POLY);
          sh    <= {sh[DATA_W-2:0], 1'b0};
          cnt   <= cnt - 1'b1;
        end else if (wr_en) begin
          sh  <= wr_data;
          cnt <= CNT_W'(DATA_W);
        end
      end
      assign busy = (cnt != '0);

      AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DATA_W)); // R8
      AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (busy && !hold_clr && cnt == CNT_W'(1)) |=> !busy); // R8
    end
  endgenerate

  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    hold_clr |=> (crc_q == '0)); // R4
  AST_HOLD_DISCARD: assert property (@(posedge clk) disable iff (rst)
    (hold_clr && wr_en) |=> (crc_q == '0) && !busy); // R5
endmodule

// File: rtl/crc_zero_detect.sv
module crc_zero_detect
  import crc_group_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  crc_t crc_q,
  input  logic busy,
  input  logic stat_rd,
  output logic pass_o,
  output logic stat_pass
);
  logic zero_now;
  assign zero_now = (crc_q == '0) && !busy;

  always_ff @(posedge clk) begin
    if (rst) pass_o <= 1'b1;
    else     pass_o <= zero_now;
  end

  always_ff @(posedge clk) begin
    if (rst)          stat_pass <= 1'b0;
    else if (stat_rd) stat_pass <= zero_now;
  end

  AST_STAT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> $stable(stat_pass)); // R7
  AST_PASS_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> !pass_o); // R3
endmodule

// File: rtl/crc_group_checker.sv
module crc_group_checker
  import crc_group_pkg::*;
#(
  parameter crc_t POLY   = 16'h1021,
  parameter int   DATA_W = 8,
  parameter bit   MODE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_clr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_rd,
  output logic              busy,
  output logic              pass_o,
  output logic              stat_pass
);
  crc_t crc_q;

  crc_byte_engine #(.POLY(POLY), .DATA_W(DATA_W), .MODE(MODE)) u_engine (
    .clk(clk), .rst(rst), .hold_clr(hold_clr), .wr_en(wr_en),
    .wr_data(wr_data), .crc_q(crc_q), .busy(busy)
  );

  crc_zero_detect u_zero (
    .clk(clk), .rst(rst), .crc_q(crc_q), .busy(busy),
    .stat_rd(stat_rd), .pass_o(pass_o), .stat_pass(stat_pass)
  );

  AST_HOLD_PASS: assert property (@(posedge clk) disable iff (rst)
    ($past(hold_clr) && hold_clr) |=> pass_o); // R4
endmodule

// File: tb/crc_group_checker_test.sv
module crc_group_checker_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold_clr = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic stat_rd = 1'b0;
  logic busy_p, pass_p, stat_p;
  logic busy_s, pass_s, stat_s;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  crc_group_checker #(.MODE(1'b0)) uut (
    .clk(clk), .rst(rst), .hold_clr(hold_clr), .wr_en(wr_en), .wr_data(wr_data),
    .stat_rd(stat_rd), .busy(busy_p), .pass_o(pass_p), .stat_pass(stat_p));

  crc_group_checker #(.MODE(1'b1)) uut_bit (
    .clk(clk), .rst(rst), .hold_clr(hold_clr), .wr_en(wr_en), .wr_data(wr_data),
    .stat_rd(stat_rd), .busy(busy_s), .pass_o(pass_s), .stat_pass(stat_s));

  localparam logic [31:0] MSGS [8] = '{32'h00000000, 32'hFFFFFFFF, 32'h12345678,
    32'hDEADBEEF, 32'h80000001, 32'hA5A55A5A, 32'h0000FF00, 32'hC0FFEE11};

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      r = (r[15] ^ b[i]) ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Write one byte, then leave time for the bitwise instance to finish.
  task automatic put(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic clear_both();
    @(negedge clk); hold_clr = 1'b1;
    repeat (2) @(negedge clk); hold_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] c;
    logic [7:0] kat [9];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 pass after reset", pass_p, 1'b1);
    chk("R9 stat after reset", stat_p, 1'b0);
    chk("R9 bit-variant pass after reset", pass_s, 1'b1);

    // R1 / R6: table of groups, no clear between passing groups
    for (int v = 0; v < 8; v++) begin
      c = 16'h0000;
      for (int k = 3; k >= 0; k--) begin
        c = ref_crc(c, MSGS[v][k*8 +: 8]);
        put(MSGS[v][k*8 +: 8]);
      end
      put(c[15:8]);
      put(c[7:0]);
      chk("R1 R6 table group pass", pass_p, 1'b1);
      chk("R8 bitwise table group pass", pass_s, 1'b1);
    end

    // R1: corrupted check word fails
    c = ref_crc(ref_crc(16'h0000, 8'h3C), 8'h7E);
    put(8'h3C); put(8'h7E); put(c[15:8]); put(c[7:0] ^ 8'h01);
    chk("R1 corrupted word fails", pass_p, 1'b0);
    chk("R8 bitwise corrupted fails", pass_s, 1'b0);

    // R4: hold clears both
    clear_both();
    chk("R4 hold clears", pass_p, 1'b1);
    chk("R4 hold clears bitwise", pass_s, 1'b1);

    // R1 known answer: "123456789" with check word 0x31C3
    kat = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    for (int i = 0; i < 9; i++) put(kat[i]);
    chk("R1 known answer before word", pass_p, 1'b0);
    put(8'h31);
    // R3 exact latency on the single-clock variant
    @(negedge clk); wr_en = 1'b1; wr_data = 8'hC3;
    @(negedge clk); wr_en = 1'b0;
    chk("R3 pass not yet updated", pass_p, 1'b0);
    @(negedge clk);
    chk("R3 pass one clock after absorb", pass_p, 1'b1);
    repeat (10) @(negedge clk);
    chk("R1 known answer bitwise", pass_s, 1'b1);

    // R7 status capture
    put(8'h5A);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk("R7 stat captures fail", stat_p, 1'b0);
    clear_both();
    chk("R7 stat unchanged without read", stat_p, 1'b0);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk("R7 stat captures pass", stat_p, 1'b1);

    // R5: write during hold discarded
    @(negedge clk); hold_clr = 1'b1; wr_en = 1'b1; wr_data = 8'hA7;
    @(negedge clk); hold_clr = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 write under hold discarded", pass_p, 1'b1);
    chk("R5 write under hold discarded bitwise", pass_s, 1'b1);

    // R2: long group
    c = 16'h0000;
    for (int i = 0; i < 300; i++) begin
      c = ref_crc(c, 8'(i * 7 + 3));
      put(8'(i * 7 + 3));
    end
    put(c[15:8]); put(c[7:0]);
    chk("R2 long group pass", pass_p, 1'b1);
    chk("R2 long group pass bitwise", pass_s, 1'b1);

    // R8: bitwise busy window and dropped write
    clear_both();
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h12;
    @(negedge clk); wr_data = 8'h34;
    chk("R8 busy after accept", busy_s, 1'b1);
    @(negedge clk); wr_en = 1'b0;
    repeat (6) @(negedge clk);
    chk("R8 busy on eighth step", busy_s, 1'b1);
    @(negedge clk);
    chk("R8 idle after eight steps", busy_s, 1'b0);
    c = ref_crc(16'h0000, 8'h12);
    put(c[15:8]); put(c[7:0]);
    chk("R8 dropped byte ignored", pass_s, 1'b1);

    // R9: reset mid-group
    put(8'h99);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R9 reset restores pass", pass_p, 1'b1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule